// File: doc/BRIEF.md
# Rectangle Copy and Fill Setup Unit

This unit sits in front of a 2D drawing engine and turns one rectangle request into the starting values the engine needs. A request is either a screen-to-screen copy or a solid fill. For copies it picks the scan order so that a source and a destination that overlap are handled safely: it walks from the far edge whenever the destination lies further along an axis than the source.

When the packed 24-bit pixel mode is selected, the engine works in bytes. The unit therefore multiplies every horizontal quantity by three before anything else. It also derives a 3-bit byte-rotation code, modulo 6, from the final starting destination X.

Requests enter on a valid/ready channel, and results leave on a second valid/ready channel one cycle after acceptance. A result is held unchanged while the consumer withholds ready. No new request is accepted until the pending result has been taken. A request with a zero width or a zero height is accepted and discarded, and produces no result.

Top module: `blit_setup_top`

## Requirements
- R1: A request accepted with width 0 or height 0 produces no result: out_valid stays low in the next cycle.
- R2: With in_mode24 = 1, source X, destination X and width are each multiplied by 3, truncated to the coordinate width, before any other step. With in_mode24 = 0 they pass through unchanged.
- R3: For a copy (in_copy = 1) with source Y < destination Y, the vertical flag is 0 (bottom-to-top) and both starting Y values are raised by height-1. Otherwise the flag is 1 (top-to-bottom) and the Y values are unchanged.
- R4: For a copy with scaled source X < scaled destination X, the horizontal flag is 0 (right-to-left) and both starting X values are raised by scaled width-1. Otherwise the flag is 1 (left-to-right) and the X values are unchanged.
- R5: A fill (in_copy = 0) sets both flags to 1, starts at the scaled destination X and the unmodified destination Y, and reports source coordinates of zero.
- R6: With in_mode24 = 1, the rotation code is floor(dx/4) mod 6 when moving left-to-right and floor((dx+2)/4) mod 6 when moving right-to-left, where dx is the final starting destination X. With in_mode24 = 0 the code is 0.
- R7: The control word has bit 0 = horizontal flag, bit 1 = vertical flag, bit 4 = last-pixel flag (always 1), bit 7 = rotation enable (equal to in_mode24), and bits 10:8 = rotation code. All other bits are 0.
- R8: The position word is {start destination X, start destination Y}, with X in the upper half. The size word is {scaled width, height}, with width in the upper half.
- R9: A result appears on out_valid in the cycle after its request is accepted. It stays stable while out_ready is low. in_ready is low whenever a result is pending.
- R10: out_x_ltr and out_y_ttb equal control-word bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_copy | input | 1 | 1 = copy, 0 = fill |
| in_mode24 | input | 1 | Packed 24-bit pixel mode |
| in_src_x | input | COORD_W | Source X in pixels |
| in_src_y | input | COORD_W | Source Y |
| in_dst_x | input | COORD_W | Destination X in pixels |
| in_dst_y | input | COORD_W | Destination Y |
| in_width | input | COORD_W | Width in pixels |
| in_height | input | COORD_W | Height in lines |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_src_x | output | COORD_W | Starting source X |
| out_src_y | output | COORD_W | Starting source Y |
| out_dst_x | output | COORD_W | Starting destination X |
| out_dst_y | output | COORD_W | Starting destination Y |
| out_x_ltr | output | 1 | 1 = left-to-right |
| out_y_ttb | output | 1 | 1 = top-to-bottom |
| out_ctrl | output | 32 | Control word |
| out_pos | output | 2*COORD_W | Packed destination position |
| out_size | output | 2*COORD_W | Packed size |

## Verification
In 24-bit mode, the times-three scaling and the right-to-left reversal of a copy fall into the same request. The rotation code must then be taken from the X value that has already been both scaled and advanced by the scaled width minus one. This case is provoked by sweeping every small source/destination X pair, in both modes, with source X below destination X. The bench judges it by recomputing the scaled start and the mod-6 code arithmetically. The same sweep also meets the zero-size drop on the cycle after a held result is released, which confirms that the discarded request leaves out_valid low.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int CTRL_W      = 32;
  localparam int BIT_X_LTR   = 0;
  localparam int BIT_Y_TTB   = 1;
  localparam int BIT_LASTPIX = 4;
  localparam int BIT_ROT_EN  = 7;
  localparam int ROT_LSB     = 8;
  localparam int ROT_W       = 3;
  localparam int ROT_MOD     = 6;
  localparam int ROT_SPAN    = 4 * ROT_MOD;

  typedef enum logic {OP_FILL = 1'b0, OP_COPY = 1'b1} op_e;
endpackage

// File: rtl/blit_scale.sv
module blit_scale #(
  parameter int W = 16
) (
  input  logic         mode24,
  input  logic [W-1:0] val_in,
  output logic [W-1:0] val_out
);
  logic [W-1:0] doubled;
  assign doubled = {val_in[W-2:0], 1'b0};
  assign val_out = mode24 ? (val_in + doubled) : val_in;
endmodule

// File: rtl/blit_orient.sv
module blit_orient #(
  parameter int W = 16
) (
  input  blit_pkg::op_e op,
  input  logic [W-1:0]  sx,
  input  logic [W-1:0]  sy,
  input  logic [W-1:0]  dx,
  input  logic [W-1:0]  dy,
  input  logic [W-1:0]  wd,
  input  logic [W-1:0]  ht,
  output logic [W-1:0]  sx_start,
  output logic [W-1:0]  sy_start,
  output logic [W-1:0]  dx_start,
  output logic [W-1:0]  dy_start,
  output logic          x_ltr,
  output logic          y_ttb
);
  logic         is_copy;
  logic         rev_y;
  logic         rev_x;
  logic [W-1:0] ht_m1;
  logic [W-1:0] wd_m1;

  assign is_copy = (op == blit_pkg::OP_COPY);
  assign rev_y   = is_copy && (sy < dy);
  assign rev_x   = is_copy && (sx < dx);
  assign ht_m1   = ht - W'(1);
  assign wd_m1   = wd - W'(1);

  always_comb begin
    y_ttb = !rev_y;
    x_ltr = !rev_x;
    if (is_copy) begin
      sy_start = rev_y ? sy + ht_m1 : sy;
      dy_start = rev_y ? dy + ht_m1 : dy;
      sx_start = rev_x ? sx + wd_m1 : sx;
      dx_start = rev_x ? dx + wd_m1 : dx;
    end else begin
      sx_start = '0;
      sy_start = '0;
      dx_start = dx;
      dy_start = dy;
    end
  end
endmodule

// File: rtl/blit_rotate.sv
module blit_rotate #(
  parameter int W = 16
) (
  input  logic                          mode24,
  input  logic                          x_ltr,
  input  logic [W-1:0]                  dx,
  output logic [blit_pkg::ROT_W-1:0]    rot,
  output logic                          rot_en
);
  localparam int RW = 5;

  logic [W:0]    base;
  logic [RW-1:0] rem_q;
  logic [RW:0]   step;

  assign base = x_ltr ? {1'b0, dx} : ({1'b0, dx} + (W+1)'(2));

  // Long division by 24 over all bits of base; floor(base/4) mod 6 is
  // then floor((base mod 24)/4).
  always_comb begin
    rem_q = '0;
    step  = '0;
    for (int i = W; i >= 0; i--) begin
      step = {rem_q, base[i]};
      if (step >= (RW+1)'(blit_pkg::ROT_SPAN))
        step = step - (RW+1)'(blit_pkg::ROT_SPAN);
      rem_q = step[RW-1:0];
    end
  end

  always_comb begin
    if (!mode24)             rot = '0;
    else if (rem_q >= 5'd20) rot = 3'd5;
    else if (rem_q >= 5'd16) rot = 3'd4;
    else if (rem_q >= 5'd12) rot = 3'd3;
    else if (rem_q >= 5'd8)  rot = 3'd2;
    else if (rem_q >= 5'd4)  rot = 3'd1;
    else                     rot = 3'd0;
  end

  assign rot_en = mode24;
endmodule

// File: rtl/blit_setup_top.sv
module blit_setup_top #(
  parameter int COORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_copy,
  input  logic                     in_mode24,
  input  logic [COORD_W-1:0]       in_src_x,
  input  logic [COORD_W-1:0]       in_src_y,
  input  logic [COORD_W-1:0]       in_dst_x,
  input  logic [COORD_W-1:0]       in_dst_y,
  input  logic [COORD_W-1:0]       in_width,
  input  logic [COORD_W-1:0]       in_height,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [COORD_W-1:0]       out_src_x,
  output logic [COORD_W-1:0]       out_src_y,
  output logic [COORD_W-1:0]       out_dst_x,
  output logic [COORD_W-1:0]       out_dst_y,
  output logic                     out_x_ltr,
  output logic                     out_y_ttb,
  output logic [31:0]              out_ctrl,
  output logic [2*COORD_W-1:0]     out_pos,
  output logic [2*COORD_W-1:0]     out_size
);
  import blit_pkg::*;

  localparam int NSCALE = 3;

  logic [COORD_W-1:0] raw_h   [NSCALE];
  logic [COORD_W-1:0] scl_h   [NSCALE];
  logic [COORD_W-1:0] sx_st, sy_st, dx_st, dy_st;
  logic               ltr_c, ttb_c;
  logic [ROT_W-1:0]   rot_c;
  logic               rot_en_c;
  logic               accept;
  logic               nonzero;
  op_e                op_c;

  assign raw_h[0] = in_src_x;
  assign raw_h[1] = in_dst_x;
  assign raw_h[2] = in_width;

  for (genvar g = 0; g < NSCALE; g++) begin : g_scale
    blit_scale #(.W(COORD_W)) u_scale (
      .mode24 (in_mode24),
      .val_in (raw_h[g]),
      .val_out(scl_h[g])
    );
  end

  assign op_c = in_copy ? OP_COPY : OP_FILL;

  blit_orient #(.W(COORD_W)) u_orient (
    .op      (op_c),
    .sx      (scl_h[0]),
    .sy      (in_src_y),
    .dx      (scl_h[1]),
    .dy      (in_dst_y),
    .wd      (scl_h[2]),
    .ht      (in_height),
    .sx_start(sx_st),
    .sy_start(sy_st),
    .dx_start(dx_st),
    .dy_start(dy_st),
    .x_ltr   (ltr_c),
    .y_ttb   (ttb_c)
  );

  blit_rotate #(.W(COORD_W)) u_rotate (
    .mode24(in_mode24),
    .x_ltr (ltr_c),
    .dx    (dx_st),
    .rot   (rot_c),
    .rot_en(rot_en_c)
  );

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;
  assign nonzero  = (in_width != '0) && (in_height != '0);

  logic [COORD_W-1:0] wd_q, ht_q;
  logic [ROT_W-1:0]   rot_q;
  logic               rot_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_src_x <= '0;
      out_src_y <= '0;
      out_dst_x <= '0;
      out_dst_y <= '0;
      out_x_ltr <= 1'b0;
      out_y_ttb <= 1'b0;
      wd_q      <= '0;
      ht_q      <= '0;
      rot_q     <= '0;
      rot_en_q  <= 1'b0;
    end else if (accept) begin
      out_valid <= nonzero;
      if (nonzero) begin
        out_src_x <= sx_st;
        out_src_y <= sy_st;
        out_dst_x <= dx_st;
        out_dst_y <= dy_st;
        out_x_ltr <= ltr_c;
        out_y_ttb <= ttb_c;
        wd_q      <= scl_h[2];
        ht_q      <= in_height;
        rot_q     <= rot_c;
        rot_en_q  <= rot_en_c;
      end
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_comb begin
    out_ctrl                            = '0;
    out_ctrl[BIT_X_LTR]                 = out_x_ltr;
    out_ctrl[BIT_Y_TTB]                 = out_y_ttb;
    out_ctrl[BIT_LASTPIX]               = 1'b1;
    out_ctrl[BIT_ROT_EN]                = rot_en_q;
    out_ctrl[ROT_LSB +: ROT_W]          = rot_q;
  end

  assign out_pos  = {out_dst_x, out_dst_y};
  assign out_size = {wd_q, ht_q};
endmodule

// File: rtl/blit_setup_chk.sv
module blit_setup_chk #(
  parameter int COORD_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [COORD_W-1:0]   in_width,
  input logic [COORD_W-1:0]   in_height,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [31:0]          out_ctrl,
  input logic [2*COORD_W-1:0] out_pos,
  input logic [2*COORD_W-1:0] out_size
);
  a_r1_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_width == '0 || in_height == '0)) |=> !out_valid);

  a_r9_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_width != '0 && in_height != '0) |=> out_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl)
                                   && $stable(out_pos) && $stable(out_size)));

  a_r9_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r6_rot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ctrl[10:8] < 3'd6));

  a_r8_size_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size[COORD_W-1:0] != '0));
endmodule

bind blit_setup_top blit_setup_chk #(.COORD_W(COORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_width (in_width),
  .in_height(in_height),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_ctrl (out_ctrl),
  .out_pos  (out_pos),
  .out_size (out_size)
);

// File: tb/tb_blit_setup_top.sv
`timescale 1ns/1ps
module tb_blit_setup_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_copy = 1'b0;
  logic in_mode24 = 1'b0;
  logic [W-1:0] in_src_x = '0, in_src_y = '0, in_dst_x = '0, in_dst_y = '0;
  logic [W-1:0] in_width = '0, in_height = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_src_x, out_src_y, out_dst_x, out_dst_y;
  logic out_x_ltr, out_y_ttb;
  logic [31:0] out_ctrl;
  logic [2*W-1:0] out_pos, out_size;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  blit_setup_top #(.COORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_copy(in_copy), .in_mode24(in_mode24),
    .in_src_x(in_src_x), .in_src_y(in_src_y),
    .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .in_width(in_width), .in_height(in_height),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src_x(out_src_x), .out_src_y(out_src_y),
    .out_dst_x(out_dst_x), .out_dst_y(out_dst_y),
    .out_x_ltr(out_x_ltr), .out_y_ttb(out_y_ttb),
    .out_ctrl(out_ctrl), .out_pos(out_pos), .out_size(out_size)
  );

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Expected values, computed from the requirements
  int e_sx, e_sy, e_dx, e_dy, e_w, e_rot, e_ltr, e_ttb;
  logic [31:0] e_ctrl;

  task automatic model(input int op, input int m, input int sx, input int sy,
                       input int dx, input int dy, input int w, input int h);
    int sxs, dxs, ws;
    sxs = m ? sx * 3 : sx;
    dxs = m ? dx * 3 : dx;
    ws  = m ? w * 3 : w;
    if (op == 1) begin
      e_ttb = (sy < dy) ? 0 : 1;
      e_ltr = (sxs < dxs) ? 0 : 1;
      e_sy = e_ttb ? sy : sy + h - 1;
      e_dy = e_ttb ? dy : dy + h - 1;
      e_sx = e_ltr ? sxs : sxs + ws - 1;
      e_dx = e_ltr ? dxs : dxs + ws - 1;
    end else begin
      e_ttb = 1; e_ltr = 1;
      e_sx = 0; e_sy = 0; e_dx = dxs; e_dy = dy;
    end
    e_w = ws;
    if (m == 0) e_rot = 0;
    else if (e_ltr == 1) e_rot = (e_dx / 4) % 6;
    else e_rot = ((e_dx + 2) / 4) % 6;
    e_ctrl = 32'(e_ltr) | (32'(e_ttb) << 1) | (32'd1 << 4) | (32'(m) << 7)
             | (32'(e_rot) << 8);
  endtask

  task automatic check_out(input int h);
    chk(64'(out_valid), 64'd1, "R9 result valid");
    chk(64'(in_ready), 64'd0, "R9 busy");
    chk({out_src_x, out_dst_x}, {16'(e_sx), 16'(e_dx)}, "R2 R4 start X");
    chk({out_src_y, out_dst_y}, {16'(e_sy), 16'(e_dy)}, "R3 R5 start Y");
    chk(64'(out_ctrl), 64'(e_ctrl), "R6 R7 ctrl");
    chk({out_x_ltr, out_y_ttb}, {1'(e_ltr), 1'(e_ttb)}, "R10 flags");
    chk({out_pos, out_size}, {16'(e_dx), 16'(e_dy), 16'(e_w), 16'(h)}, "R8 words");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(64'(out_valid), 64'd0, "R9 reset valid");
    chk(64'(in_ready), 64'd1, "R9 reset ready");

    for (int op = 0; op < 2; op++)
      for (int m = 0; m < 2; m++)
        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 3; h++)
            for (int sx = 0; sx < 6; sx++)
              for (int dx = 0; dx < 6; dx++)
                for (int sy = 0; sy < 3; sy++)
                  for (int dy = 0; dy < 3; dy++) begin
                    idx++;
                    in_copy = 1'(op); in_mode24 = 1'(m);
                    in_src_x = 16'(sx); in_src_y = 16'(sy);
                    in_dst_x = 16'(dx); in_dst_y = 16'(dy);
                    in_width = 16'(w); in_height = 16'(h);
                    in_valid = 1'b1;
                    out_ready = 1'b0;
                    chk(64'(in_ready), 64'd1, "R9 idle ready");
                    @(negedge clk);
                    in_valid = 1'b0;
                    if (w == 0 || h == 0) begin
                      chk(64'(out_valid), 64'd0, "R1 zero size dropped");
                    end else begin
                      model(op, m, sx, sy, dx, dy, w, h);
                      check_out(h);
                      if (idx % 7 == 0) begin
                        repeat (2) begin
                          @(negedge clk);
                          check_out(h);
                        end
                      end
                      out_ready = 1'b1;
                      @(negedge clk);
                      out_ready = 1'b0;
                      chk(64'(out_valid), 64'd0, "R9 taken");
                    end
                  end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule